// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master that runs one complete flash command each time software requests it. Software writes a command opcode and a pair of byte counts, loads the outgoing payload into a small byte buffer through a data port, and then sets a start bit. The engine lowers chip select, shifts the opcode out, shifts the buffered payload bytes out, and then clocks in the requested number of reply bytes. It raises chip select again one SCK period after the last bit.

The opcode never passes through the buffer. Transmit and receive share the one buffer. Reply bytes are placed directly behind the payload bytes. After a command, software rewinds the buffer pointer and reads from the start: it first sees the bytes it sent and then the reply. The pointer can be rewound at any time and can be read back. The serial side runs in SPI mode 0, and the SCK rate is the system clock divided by a fixed parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, the busy indication is 0, the buffer pointer reads 0, and the opcode and count registers read 0.
- R2: Offset 0x0 holds the opcode byte. Offset 0x1 holds the counts: bits 3:0 are the number of payload bytes and bits 7:4 are the number of reply bytes. Both registers read back what was written.
- R3: Every read or write of the data port at offset 0xC uses the entry at the current pointer and then advances the pointer by one, modulo the buffer depth of 8. Offset 0xD returns the pointer in bits 2:0, with the other bits 0.
- R4: Writing offset 0x2 with bit 4 set returns the pointer to 0.
- R5: Writing offset 0x2 with bit 0 set starts a command when the engine is idle. While the command runs, offset 0x2 bit 0 and offset 0x3 bit 7 both read 1.
- R6: On MOSI, the engine sends the opcode first, then buffer entries 0 to N-1, where N is the payload count. It sends 0x00 during each reply byte. Every byte goes MSB first. MOSI changes only while SCK is low, and MOSI is stable while SCK is high (mode 0).
- R7: MISO is sampled on each rising SCK edge. Reply byte n is stored at buffer index (N + n) mod 8, so reading from index 0 after a command returns the payload bytes and then the reply bytes.
- R8: Chip select stays low from the first bit to the last bit of a command. It returns high between 2*DIV and 2*DIV+2 clock cycles after the final falling SCK edge. SCK is low whenever chip select is high.
- R9: While a command runs, writes to the opcode register, the count register and the data port have no effect. A blocked data-port write does not move the pointer.
- R10: A single one-cycle pulse on the completion output marks each command's end. It appears in the first cycle in which busy reads 0 again.
- R11: A payload count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the pointer when the data port is addressed) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, valid in the same cycle |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| done_pulse | output | 1 | One-cycle pulse when a command completes |

## Verification
The hardest case to reach is a reply that wraps around the shared buffer. With a full payload of eight bytes, or a payload count clamped down to eight, the reply overwrites payload entries. Those entries must then be read back with the reply values, while entries the reply did not reach keep their payload values. The bench reaches this case by programming payload counts of 8 and 12, and it keeps its own model of buffer contents and pointer to predict every readback. It also tries writes that must be ignored while a command is in flight. The serial device in the bench returns a distinct byte at every position, so each reply byte lands at a checkable index.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   localparam logic [3:0] A_OPC = 4'h0;
   localparam logic [3:0] A_CNT = 4'h1;
   localparam logic [3:0] A_CTL = 4'h2;
   localparam logic [3:0] A_STS = 4'h3;
   localparam logic [3:0] A_DAT = 4'hC;
   localparam logic [3:0] A_PTR = 4'hD;

   localparam int unsigned CTL_GO_BIT  = 0;
   localparam int unsigned CTL_CLR_BIT = 4;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_SHIFT = 2'd1,
      S_TAIL  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_clr,
   input  logic             sw_adv,
   input  logic             sw_we,
   input  logic [7:0]       sw_wdata,
   output logic [7:0]       sw_rdata,
   output logic [PTR_W-1:0] ptr,
   input  logic             eng_we,
   input  logic [PTR_W-1:0] eng_waddr,
   input  logic [7:0]       eng_wdata,
   input  logic [PTR_W-1:0] eng_raddr,
   output logic [7:0]       eng_rdata
);

   logic [7:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (eng_we && eng_waddr == PTR_W'(i))
            ent[i] <= eng_wdata;
         else if (sw_we && ptr == PTR_W'(i))
            ent[i] <= sw_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (ptr_clr) ptr <= '0;
      else if (sw_adv)  ptr <= ptr + 1'b1;
   end

   assign sw_rdata  = ent[ptr];
   assign eng_rdata = ent[eng_raddr];

   p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_clr |=> (ptr == '0));

   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_adv && !ptr_clr) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   p_single_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_we && eng_we));

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
   parameter int unsigned DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

   logic          act;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sh_tx;
   logic [7:0]    sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act   <= 1'b0;
         sck   <= 1'b0;
         cnt   <= '0;
         bitn  <= '0;
         sh_tx <= '0;
         sh_rx <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            act   <= 1'b1;
            sck   <= 1'b0;
            cnt   <= '0;
            bitn  <= '0;
            sh_tx <= tx_byte;
         end else if (act) begin
            if (cnt == CNT_LAST) begin
               cnt <= '0;
               if (!sck) begin
                  sck   <= 1'b1;
                  sh_rx <= {sh_rx[6:0], miso};
               end else begin
                  sck <= 1'b0;
                  if (bitn == 3'd7) begin
                     act  <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bitn  <= bitn + 1'b1;
                     sh_tx <= {sh_tx[6:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign mosi    = act & sh_tx[7];
   assign rx_byte = sh_rx;

   p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !act);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int unsigned DIV        = 2,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter logic [7:0]  RX_FILL    = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso,
   output logic       spi_cs_n,
   output logic       done_pulse
);

   localparam int unsigned PTR_W  = $clog2(FIFO_DEPTH);
   localparam int unsigned IDX_W  = 5;
   localparam int unsigned TAIL_N = 2 * DIV;
   localparam int unsigned TAIL_W = $clog2(TAIL_N) + 1;

   if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
   end
   if (FIFO_DEPTH != 2 && FIFO_DEPTH != 4 && FIFO_DEPTH != 8) begin : g_bad_depth
      $error("FIFO_DEPTH must be 2, 4 or 8");
   end

   seq_state_t        state;
   logic [IDX_W-1:0]  idx;
   logic [TAIL_W-1:0] tail_cnt;
   logic [7:0]        opcode_q;
   logic [7:0]        cnt_q;

   logic              busy, go, ptr_clr, acc_dat;
   logic              sw_we, sw_adv;
   logic [7:0]        sw_rdata, eng_rdata;
   logic [PTR_W-1:0]  ptr, eng_raddr, eng_waddr;
   logic              eng_we;
   logic [IDX_W-1:0]  tx_eff, total, nxt_j;
   logic              more, launch;
   logic [7:0]        launch_byte;
   logic              sh_done;
   logic [7:0]        sh_rx;

   assign busy    = (state != S_IDLE);
   assign acc_dat = (reg_addr == A_DAT);
   assign go      = reg_wr && (reg_addr == A_CTL) && reg_wdata[CTL_GO_BIT] && !busy;
   assign ptr_clr = reg_wr && (reg_addr == A_CTL) && reg_wdata[CTL_CLR_BIT];
   assign sw_we   = reg_wr && acc_dat && !busy;
   assign sw_adv  = acc_dat && (reg_rd || sw_we);

   always_comb begin
      if (int'(cnt_q[3:0]) > FIFO_DEPTH) tx_eff = IDX_W'(FIFO_DEPTH);
      else                               tx_eff = IDX_W'(cnt_q[3:0]);
   end

   assign total  = IDX_W'(1) + tx_eff + IDX_W'(cnt_q[7:4]);
   assign nxt_j  = busy ? (idx + 1'b1) : '0;
   assign more   = (nxt_j < total);
   assign launch = go || ((state == S_SHIFT) && sh_done && more);

   assign eng_raddr = PTR_W'(nxt_j - 1'b1);
   assign eng_waddr = PTR_W'(idx - 1'b1);
   assign eng_we    = (state == S_SHIFT) && sh_done && (idx > tx_eff);

   always_comb begin
      if (nxt_j == '0)          launch_byte = opcode_q;
      else if (nxt_j <= tx_eff) launch_byte = eng_rdata;
      else                      launch_byte = RX_FILL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         cnt_q    <= '0;
      end else if (reg_wr && !busy) begin
         if (reg_addr == A_OPC) opcode_q <= reg_wdata;
         if (reg_addr == A_CNT) cnt_q    <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         idx        <= '0;
         tail_cnt   <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (go) begin
                  state <= S_SHIFT;
                  idx   <= '0;
               end
            end
            S_SHIFT: begin
               if (sh_done) begin
                  if (more) begin
                     idx <= nxt_j;
                  end else begin
                     state    <= S_TAIL;
                     tail_cnt <= '0;
                  end
               end
            end
            S_TAIL: begin
               if (tail_cnt == TAIL_W'(TAIL_N - 1)) begin
                  state      <= S_IDLE;
                  done_pulse <= 1'b1;
               end else begin
                  tail_cnt <= tail_cnt + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign spi_cs_n = (state == S_IDLE);

   always_comb begin
      unique case (reg_addr)
         A_OPC:   reg_rdata = opcode_q;
         A_CNT:   reg_rdata = cnt_q;
         A_CTL:   reg_rdata = {7'b0, busy};
         A_STS:   reg_rdata = {busy, 7'b0};
         A_DAT:   reg_rdata = sw_rdata;
         A_PTR:   reg_rdata = 8'(ptr);
         default: reg_rdata = '0;
      endcase
   end

   spi_cmd_fifo #(
      .DEPTH (FIFO_DEPTH),
      .PTR_W (PTR_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_clr   (ptr_clr),
      .sw_adv    (sw_adv),
      .sw_we     (sw_we),
      .sw_wdata  (reg_wdata),
      .sw_rdata  (sw_rdata),
      .ptr       (ptr),
      .eng_we    (eng_we),
      .eng_waddr (eng_waddr),
      .eng_wdata (sh_rx),
      .eng_raddr (eng_raddr),
      .eng_rdata (eng_rdata)
   );

   spi_cmd_shift #(
      .DIV (DIV)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .tx_byte (launch_byte),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   p_sck_low_when_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!busy && $past(busy)));

   p_opcode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == A_OPC) |=> $stable(opcode_q));

   p_count_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == A_CNT) |=> $stable(cnt_q));

endmodule

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

   localparam int DIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_mosi, spi_cs_n, done_pulse;
   logic       spi_miso = 1'b0;

   spi_cmd_engine #(.DIV(DIV), .FIFO_DEPTH(8), .RX_FILL(8'h00)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .done_pulse(done_pulse)
   );

   always #2.5 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   int dcount = 0;
   int last_fall = 0;
   int cs_rise = 0;
   int s_bits = 0;
   bit finished = 0;
   bit mosi_q[$];

   logic [7:0] mdl_mem [8];
   int         mdl_ptr = 0;

   function automatic logic [7:0] resp(int k);
      return 8'(8'h5A ^ (k * 8'h13) ^ (k << 5));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // serial device model, mode 0
   always @(negedge spi_cs_n) begin
      s_bits = 0;
      spi_miso = resp(0)[7];
   end
   always @(negedge spi_sck) begin
      last_fall = cyc;
      if (!spi_cs_n) begin
         s_bits++;
         spi_miso = resp(s_bits / 8)[7 - (s_bits % 8)];
      end
   end
   always @(posedge spi_sck) mosi_q.push_back(spi_mosi);
   always @(posedge spi_cs_n) cs_rise = cyc;

   // per-clock comparison of the serial pins against the idle rule
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_pulse) dcount++;
         vectors++;
         if (spi_cs_n && spi_sck) begin
            miscompares++;
            $display("FAIL R8 actual=sck high expected=sck low while deselected");
         end
      end
   end

   task automatic wr(logic [3:0] a, logic [7:0] d, bit ignored = 0);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 4'h2 && d[4]) mdl_ptr = 0;
      if (a == 4'hC && !ignored) begin
         mdl_mem[mdl_ptr] = d;
         mdl_ptr = (mdl_ptr + 1) % 8;
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
      if (a == 4'hC) mdl_ptr = (mdl_ptr + 1) % 8;
   endtask

   task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, {24'b0, v}, {24'b0, exp});
   endtask

   task automatic run_cmd(logic [7:0] opc, logic [3:0] ntx, logic [3:0] nrx,
                          logic [7:0] seed, bit poke_busy);
      logic [7:0] v;
      int te, nb, d0, guard;
      te = (ntx > 8) ? 8 : int'(ntx);
      nb = 1 + te + int'(nrx);
      wr(4'h0, opc);
      wr(4'h1, {nrx, ntx});
      wr(4'h2, 8'h10);
      for (int i = 0; i < te; i++) wr(4'hC, 8'(seed + 8'(i * 7)));
      wr(4'h2, 8'h10);
      mosi_q.delete();
      d0 = dcount;
      wr(4'h2, 8'h01);
      rd_chk("R5 status busy", 4'h3, 8'h80);
      rd_chk("R5 control go reads 1", 4'h2, 8'h01);
      if (poke_busy) begin
         wr(4'h0, 8'hEE, 1);
         wr(4'h1, 8'h77, 1);
         wr(4'hC, 8'h99, 1);
         rd_chk("R9 pointer unmoved by blocked write", 4'hD, 8'(mdl_ptr));
      end
      guard = 0;
      while (dcount == d0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      repeat (3) @(negedge clk);
      chk("R10 one completion pulse", dcount, d0 + 1);
      chk("R5 idle after completion", {31'b0, spi_cs_n}, 32'd1);
      rd_chk("R5 status idle", 4'h3, 8'h00);
      chk("R8 deselect delay window",
          32'((cs_rise - last_fall >= 2 * DIV) && (cs_rise - last_fall <= 2 * DIV + 2)), 32'd1);
      chk("R6 bit count", mosi_q.size(), 8 * nb);
      if (mosi_q.size() == 8 * nb) begin
         for (int b = 0; b < nb; b++) begin
            logic [7:0] got, exp;
            got = '0;
            for (int k = 0; k < 8; k++) got = {got[6:0], mosi_q[8 * b + k]};
            if (b == 0) exp = opc;
            else if (b <= te) exp = 8'(seed + 8'((b - 1) * 7));
            else exp = 8'h00;
            chk("R6 serial byte", {24'b0, got}, {24'b0, exp});
         end
      end
      if (poke_busy) begin
         rd_chk("R9 opcode kept", 4'h0, opc);
         rd_chk("R9 count kept", 4'h1, {nrx, ntx});
      end
      for (int n = 0; n < int'(nrx); n++) mdl_mem[(te + n) % 8] = resp(1 + te + n);
      wr(4'h2, 8'h10);
      for (int i = 0; i < te + int'(nrx); i++) begin
         logic [7:0] e;
         e = mdl_mem[mdl_ptr];
         rd_chk((i < te) ? "R7 payload readback" : "R7 reply readback", 4'hC, e);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 8; i++) mdl_mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cs_n high", {31'b0, spi_cs_n}, 32'd1);
      chk("R1 sck low", {31'b0, spi_sck}, 32'd0);
      rd_chk("R1 opcode zero", 4'h0, 8'h00);
      rd_chk("R1 count zero", 4'h1, 8'h00);
      rd_chk("R1 busy zero", 4'h3, 8'h00);
      rd_chk("R1 pointer zero", 4'hD, 8'h00);
      // R2 register readback
      wr(4'h0, 8'hA5);
      wr(4'h1, 8'h3C);
      rd_chk("R2 opcode", 4'h0, 8'hA5);
      rd_chk("R2 count", 4'h1, 8'h3C);
      // R3 pointer stepping and wrap
      for (int i = 0; i < 3; i++) wr(4'hC, 8'(8'h10 + i));
      rd_chk("R3 pointer after three", 4'hD, 8'h03);
      // R4 rewind
      wr(4'h2, 8'h10);
      rd_chk("R4 pointer cleared", 4'hD, 8'h00);
      for (int i = 0; i < 9; i++) wr(4'hC, 8'(8'h20 + i));
      rd_chk("R3 pointer wraps", 4'hD, 8'h01);
      wr(4'h2, 8'h10);
      rd_chk("R3 entry 0 overwritten by wrap", 4'hC, 8'h28);
      rd_chk("R3 entry 1", 4'hC, 8'h21);
      rd_chk("R3 pointer after reads", 4'hD, 8'h02);
      // commands
      run_cmd(8'h9F, 4'd0, 4'd3, 8'h00, 0);
      run_cmd(8'h03, 4'd3, 4'd4, 8'h40, 1);
      run_cmd(8'h0B, 4'd8, 4'd2, 8'h80, 0);   // R7 reply wraps onto payload
      run_cmd(8'h02, 4'd12, 4'd1, 8'hC0, 0);  // R11 clamp to eight
      run_cmd(8'h06, 4'd0, 4'd0, 8'h00, 0);
      rd_chk("R4 pointer after readback", 4'hD, 8'(mdl_ptr));
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule